// File: doc/BRIEF.md
# Pulse-Frequency Torque and Speed Meter

This block turns the two pulse trains of a rotating-shaft transducer into engineering values. One train carries torque as a frequency offset from a zero-torque carrier. The other carries shaft speed as one pulse per tooth of a code disk. Each input is synchronized, cleaned of short glitches and reduced to single-cycle rising-edge strobes. Its frequency is then found by reciprocal counting: the block counts reference clocks across a whole number of input periods. A measurement window closes at the first input edge after each gate interval (one millisecond at the default clock), so slow inputs still give exact results.

One shared sequential divider turns the two counts into a signed torque and a speed in rpm. The torque uses separate forward and reverse scaling around the carrier. Both results are published together with a one-cycle strobe. A channel that stops pulsing reports zero after a timeout. The scaling constants come in on configuration inputs, and the reference-clock rate, gate and timeout are parameters.

Top module: `pulse_freq_meter`

## Requirements
- R1: While reset is held and until the first publication, `torque_out` and `rpm_out` are 0 and `result_valid` is low.
- R2: With measured torque frequency f at or above the zero frequency Z0, the published torque is floor(N·(f − Z0)/(F+ − Z0)). Here N is the full-scale value and F+ is the forward full-scale frequency. f equal to Z0 gives 0.
- R3: With f below Z0, the published torque is the negative of floor(N·(Z0 − f)/(Z0 − F−)), where F− is the reverse full-scale frequency, in two's complement.
- R4: The published speed is floor(60·fs/T), where fs is the measured speed frequency in Hz and T is the tooth count.
- R5: The frequency of a channel is floor(CLK_HZ·E/C). C reference clocks span E whole input periods, and the window ends at the first input rising edge after each GATE_CYCLES gate. An input with a constant period of P clocks therefore reads floor(CLK_HZ/P).
- R6: A channel that sees no rising edge for TIMEOUT_CYCLES clocks reports frequency zero. The speed output then reads 0, and the torque output also reads 0 (no signal, not full reverse).
- R7: Each input passes a two-flop synchronizer. A level change is accepted only once it has persisted for more than `glitch_len` clocks, so a pulse of `glitch_len` clocks or fewer does not change the measurement. Each accepted rising edge yields a strobe of exactly one cycle.
- R8: `result_valid` is high for exactly one cycle when both outputs change together. Between strobes both outputs hold their values.
- R9: A publication waits until both channels have a new result. A slow speed input therefore sets the publication rate while the faster torque channel keeps refreshing its own window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock of CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| torque_pulse | input | 1 | Asynchronous torque frequency input |
| speed_pulse | input | 1 | Asynchronous speed (tooth) pulse input |
| cfg_full_scale | input | CFG_W | Torque full-scale value N |
| cfg_f_zero | input | CFG_W | Zero-torque frequency in Hz |
| cfg_f_fwd | input | CFG_W | Forward full-scale frequency in Hz |
| cfg_f_rev | input | CFG_W | Reverse full-scale frequency in Hz |
| cfg_teeth | input | CFG_W | Teeth or lines on the speed disk |
| glitch_len | input | GL_W | Longest pulse, in clocks, that is rejected |
| torque_out | output | TQ_W | Signed torque, two's complement |
| rpm_out | output | RPM_W | Shaft speed in rpm |
| result_valid | output | 1 | One-cycle strobe: both outputs just updated |

## Verification
The torque input is driven at its carrier period, above it and below it, and once at an odd period whose quotient truncates. Together these separate the forward branch, the reverse branch with its sign, and the exact-carrier boundary. The speed input is driven at several periods, with two tooth counts changed mid-run, and then at a period longer than the gate, which shows that windows stretch over whole periods and that publication waits on the slow channel. Narrow extra pulses injected between teeth must leave the speed reading unchanged. Stopping each input in turn must drive its output to zero after the timeout. Every cycle between strobes, the outputs are compared against the value last published.

// File: rtl/pulse_freq_meter.sv
module pulse_freq_meter #(
  parameter int CLK_HZ         = 50_000_000,
  parameter int GATE_CYCLES    = 50_000,
  parameter int TIMEOUT_CYCLES = 50_000_000,
  parameter int CFG_W          = 24,
  parameter int TQ_W           = 16,
  parameter int RPM_W          = 24,
  parameter int GL_W           = 8,
  parameter int DW             = 48
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    torque_pulse,
  input  logic                    speed_pulse,
  input  logic [CFG_W-1:0]        cfg_full_scale,
  input  logic [CFG_W-1:0]        cfg_f_zero,
  input  logic [CFG_W-1:0]        cfg_f_fwd,
  input  logic [CFG_W-1:0]        cfg_f_rev,
  input  logic [CFG_W-1:0]        cfg_teeth,
  input  logic [GL_W-1:0]         glitch_len,
  output logic signed [TQ_W-1:0]  torque_out,
  output logic [RPM_W-1:0]        rpm_out,
  output logic                    result_valid
);

  localparam int CLK_W  = $clog2(TIMEOUT_CYCLES + GATE_CYCLES + 2);
  localparam int GATE_W = $clog2(GATE_CYCLES + 1);
  localparam int DNW    = $clog2(DW + 1);
  localparam logic [DW-1:0] K_CLK = DW'(CLK_HZ);

  typedef enum logic [2:0] {S_IDLE, S_FT, S_TQ, S_FS, S_RPM} state_t;

  logic [1:0]            raw;
  logic [1:0]            ch_fresh, ch_rise;
  logic [1:0][CLK_W-1:0] ch_clk, ch_edge;
  logic                  consume;
  logic [GATE_W-1:0]     gate_cnt;
  wire                   gate_tick = (gate_cnt == GATE_W'(GATE_CYCLES - 1));

  assign raw = {speed_pulse, torque_pulse};

  always_ff @(posedge clk) begin
    if (rst || gate_tick) gate_cnt <= '0;
    else                  gate_cnt <= gate_cnt + 1'b1;
  end

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic [1:0]       sync;
    logic             lvl, lvl_d, started, due, fresh;
    logic [GL_W-1:0]  gcnt;
    logic [CLK_W-1:0] clks, idle, m_clk, m_edge, edges;
    wire              rise = lvl & ~lvl_d;

    always_ff @(posedge clk) begin
      if (rst) begin
        sync <= '0; lvl <= 1'b0; lvl_d <= 1'b0; gcnt <= '0;
        started <= 1'b0; due <= 1'b0; fresh <= 1'b0;
        clks <= '0; edges <= '0; idle <= '0;
        m_clk <= CLK_W'(1); m_edge <= '0;
      end else begin
        sync  <= {sync[0], raw[c]};
        lvl_d <= lvl;
        if (sync[1] == lvl)            gcnt <= '0;
        else if (gcnt >= glitch_len) begin lvl <= sync[1]; gcnt <= '0; end
        else                           gcnt <= gcnt + 1'b1;

        if (gate_tick) due   <= 1'b1;
        if (consume)   fresh <= 1'b0;

        if (rise) begin
          idle <= '0;
          if (!started) begin
            started <= 1'b1; clks <= '0; edges <= '0;
          end else if (due) begin
            m_clk  <= clks + 1'b1;
            m_edge <= edges + 1'b1;
            fresh  <= 1'b1;
            due    <= 1'b0;
            clks   <= '0; edges <= '0;
          end else begin
            clks  <= clks + 1'b1;
            edges <= edges + 1'b1;
          end
        end else begin
          if (started && clks != '1) clks <= clks + 1'b1;
          if (idle == CLK_W'(TIMEOUT_CYCLES - 1)) begin
            idle    <= '0;
            started <= 1'b0;
            due     <= 1'b0;
            m_clk   <= CLK_W'(1);
            m_edge  <= '0;
            fresh   <= 1'b1;
          end else begin
            idle <= idle + 1'b1;
          end
        end
      end
    end

    assign ch_fresh[c] = fresh;
    assign ch_rise[c]  = rise;
    assign ch_clk[c]   = m_clk;
    assign ch_edge[c]  = m_edge;
  end

  state_t                 state;
  logic [DW-1:0]          dq, dd;
  logic [DW:0]            dr;
  logic [DNW-1:0]         dn;
  logic                   dbusy;
  logic                   go;
  logic [DW-1:0]          gnum, gden;
  logic [CLK_W-1:0]       wk_clk, wk_edge;
  logic                   tq_zero, sp_zero, tq_neg;
  logic signed [TQ_W-1:0] tq_mag;

  wire [DW:0]   trial = {dr[DW-1:0], dq[DW-1]};
  wire          ge    = trial >= {1'b0, dd};
  wire [DW-1:0] f0    = DW'(cfg_f_zero);
  wire          fwd   = dq >= f0;

  assign consume = (state == S_IDLE) && (&ch_fresh);

  always_comb begin
    go = 1'b0; gnum = '0; gden = DW'(1);
    case (state)
      S_IDLE: if (&ch_fresh) begin
        go = 1'b1; gnum = K_CLK * DW'(ch_edge[0]); gden = DW'(ch_clk[0]);
      end
      S_FT: if (!dbusy) begin
        go   = 1'b1;
        gnum = DW'(cfg_full_scale) * (fwd ? dq - f0 : f0 - dq);
        gden = fwd ? DW'(cfg_f_fwd) - f0 : f0 - DW'(cfg_f_rev);
      end
      S_TQ: if (!dbusy) begin
        go = 1'b1; gnum = K_CLK * DW'(wk_edge); gden = DW'(wk_clk);
      end
      S_FS: if (!dbusy) begin
        go = 1'b1; gnum = DW'(60) * dq; gden = DW'(cfg_teeth);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; dbusy <= 1'b0; dq <= '0; dd <= '0; dr <= '0; dn <= '0;
      wk_clk <= '0; wk_edge <= '0; tq_zero <= 1'b0; sp_zero <= 1'b0;
      tq_neg <= 1'b0; tq_mag <= '0;
      torque_out <= '0; rpm_out <= '0; result_valid <= 1'b0;
    end else begin
      result_valid <= 1'b0;
      if (go) begin
        dq <= gnum; dd <= gden; dr <= '0; dn <= DNW'(DW); dbusy <= 1'b1;
      end else if (dbusy) begin
        dr <= ge ? trial - {1'b0, dd} : trial;
        dq <= {dq[DW-2:0], ge};
        dn <= dn - 1'b1;
        if (dn == DNW'(1)) dbusy <= 1'b0;
      end
      case (state)
        S_IDLE: if (&ch_fresh) begin
          wk_clk  <= ch_clk[1];
          wk_edge <= ch_edge[1];
          tq_zero <= (ch_edge[0] == '0);
          sp_zero <= (ch_edge[1] == '0);
          state   <= S_FT;
        end
        S_FT:  if (!dbusy) begin tq_neg <= !fwd; state <= S_TQ; end
        S_TQ:  if (!dbusy) begin tq_mag <= TQ_W'(dq); state <= S_FS; end
        S_FS:  if (!dbusy) state <= S_RPM;
        S_RPM: if (!dbusy) begin
          rpm_out      <= sp_zero ? '0 : RPM_W'(dq);
          torque_out   <= tq_zero ? '0 : (tq_neg ? -tq_mag : tq_mag);
          result_valid <= 1'b1;
          state        <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pulse_freq_meter_chk.sv
module pulse_freq_meter_chk #(
  parameter int TQ_W  = 16,
  parameter int RPM_W = 24
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   valid,
  input logic signed [TQ_W-1:0] torque,
  input logic [RPM_W-1:0]       rpm,
  input logic [1:0]             rise
);

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid |-> ($stable(torque) && $stable(rpm)));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!valid && torque == '0 && rpm == '0));

  // R7
  torque_edge_chk: assert property (@(posedge clk) disable iff (rst)
    rise[0] |=> !rise[0]);

  // R7
  speed_edge_chk: assert property (@(posedge clk) disable iff (rst)
    rise[1] |=> !rise[1]);

endmodule

bind pulse_freq_meter pulse_freq_meter_chk #(.TQ_W(TQ_W), .RPM_W(RPM_W)) u_chk (
  .clk(clk), .rst(rst), .valid(result_valid),
  .torque(torque_out), .rpm(rpm_out), .rise(ch_rise)
);

// File: tb/tb_pulse_freq_meter.sv
module tb_pulse_freq_meter;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 1_000_000;
  localparam int GATE       = 1000;
  localparam int TMO        = 6000;

  logic clk = 1'b0, rst = 1'b1;
  logic tq_pin = 1'b0, sp_pin = 1'b0;
  logic [23:0] n_fs = 500, f0 = 10000, fp = 15000, fr = 5000, teeth = 60;
  logic [7:0]  glen = 1;
  logic signed [15:0] torque_out;
  logic [23:0] rpm_out;
  logic        result_valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_freq_meter #(.CLK_HZ(CLK_HZ), .GATE_CYCLES(GATE), .TIMEOUT_CYCLES(TMO)) dut (
    .clk(clk), .rst(rst), .torque_pulse(tq_pin), .speed_pulse(sp_pin),
    .cfg_full_scale(n_fs), .cfg_f_zero(f0), .cfg_f_fwd(fp), .cfg_f_rev(fr),
    .cfg_teeth(teeth), .glitch_len(glen),
    .torque_out(torque_out), .rpm_out(rpm_out), .result_valid(result_valid));

  int total = 0, fails = 0, good_seen = 0, skip = 0;
  int tq_per = 0, sp_per = 0;
  bit glit = 1'b0;
  string tq_tag = "R2", sp_tag = "R4";
  longint hold_t = 0, hold_r = 0;

  task automatic chk(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint exp_torque();
    longint f;
    if (tq_per == 0) return 0;
    f = CLK_HZ / tq_per;
    if (f >= f0) return (n_fs * (f - f0)) / (fp - f0);
    return -((n_fs * (f0 - f)) / (f0 - fr));
  endfunction

  function automatic longint exp_rpm();
    if (sp_per == 0) return 0;
    return (60 * longint'(CLK_HZ / sp_per)) / teeth;
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin : gen_torque
    int pos = 0;
    forever begin
      @(negedge clk);
      if (tq_per == 0) begin tq_pin = 1'b0; pos = 0; end
      else begin
        tq_pin = (pos < tq_per / 2);
        pos = (pos >= tq_per - 1) ? 0 : pos + 1;
      end
    end
  end

  initial begin : gen_speed
    int pos = 0;
    forever begin
      @(negedge clk);
      if (sp_per == 0) begin sp_pin = 1'b0; pos = 0; end
      else begin
        sp_pin = (pos < sp_per / 2) ||
                 (glit && (pos == 3 * sp_per / 4 || pos == 3 * sp_per / 4 + 1));
        pos = (pos >= sp_per - 1) ? 0 : pos + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (result_valid) begin
        if (skip > 0) skip--;
        else begin
          chk(tq_tag, longint'(torque_out), exp_torque());
          chk(sp_tag, longint'(rpm_out), exp_rpm());
          good_seen++;
        end
        hold_t = longint'(torque_out);
        hold_r = longint'(rpm_out);
      end else begin
        chk("R8", longint'(torque_out), hold_t);
        chk("R8", longint'(rpm_out), hold_r);
      end
    end
  end

  task automatic phase(int sk, int n);
    int start;
    skip = sk;
    start = good_seen;
    while (good_seen < start + n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    total++; fails++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin : main
    repeat (5) @(negedge clk);
    chk("R1", longint'(torque_out), 0);
    chk("R1", longint'(rpm_out), 0);
    chk("R1", longint'(result_valid), 0);
    rst = 1'b0;
    tq_per = 100; sp_per = 500;
    tq_tag = "R2"; sp_tag = "R5";
    phase(3, 3);
    tq_per = 80; sp_tag = "R4";
    phase(3, 3);
    tq_per = 125; sp_per = 1000; teeth = 1024; tq_tag = "R3";
    phase(3, 3);
    tq_per = 67; sp_per = 250; tq_tag = "R2";
    phase(3, 3);
    glen = 3; glit = 1'b1; sp_per = 500; sp_tag = "R7";
    phase(3, 3);
    sp_per = 3000; sp_tag = "R9";
    phase(2, 2);
    sp_per = 0; sp_tag = "R6";
    phase(2, 2);
    tq_per = 0; tq_tag = "R6";
    phase(2, 2);
    summary();
    $finish;
  end
endmodule